// File: doc/BRIEF.md
# Drawing Command Stream Parser

This block sits at the entry of a drawing pipeline and takes in a stream of 32-bit command words through a valid/ready handshake. The top byte of the first word of each packet is the command code. A fixed table maps that code to a parameter count, so a packet has one header word plus that many parameter words. The block collects all the words of a packet in a local store. Only after the final word has been accepted does it replay the packet, word by word, on a downstream drawing port that can apply backpressure.

While it collects packets, the parser watches for commands that change state. Textured primitives copy their texture-page field into a status register. Two environment commands set texture-page and mask fields. Every environment command also stores its whole word in one of eight environment registers.

Two commands open a rectangle transfer. One moves pixels into the frame store and one moves them out of it. Neither command is forwarded. The parser takes the two words after the header as position and size and raises a one-cycle start request. After a write-direction start, every input word goes to the transfer engine until the engine reports that it is done.

Top module: `draw_cmd_parser`

## Requirements
- R1: The packet length is 1 + the parameter count of the command code in bits 31:24 of the first word. The counts are:
  - 3 for 0x20-0x23, 6 for 0x24-0x27, 4 for 0x28-0x2B, 8 for 0x2C-0x2F.
  - 5 for 0x30-0x33, 8 for 0x34-0x37, 7 for 0x38-0x3B, 11 for 0x3C-0x3F.
  - 2 for 0x02, 2 for 0x60-0x63, 1 for 0x68-0x6B, 3 for 0x80, 2 for 0xA0 and 0xC0.
- R2: A packet appears on the drawing port only after its last word is accepted. It appears in arrival order, with `pkt_last` high on the final word only. `in_ready` stays low while a packet drains.
- R3: While `pkt_valid` is high and `pkt_ready` is low, `pkt_data` and `pkt_last` hold their values and input stays stalled.
- R4: Any code not listed in R1 forms a one-word packet that is forwarded.
- R5: When (code & 0xF4) == 0x24, status bits 8:0 take bits 8:0 of packet word 4. When (code & 0xF4) == 0x34, they take bits 8:0 of packet word 5. Word 0 is the header.
- R6: Code 0xE1 loads status bits 10:0 from bits 10:0 of its word. Code 0xE6 loads status bits 12:11 from bits 1:0 of its word. Other status bits keep their values.
- R7: Any code 0xE0-0xE7 stores its full word in environment register (code & 7), visible at `env_regs[32*k +: 32]`. The word is also forwarded as a one-word packet.
- R8: Codes 0xA0 and 0xC0 are not forwarded. In the cycle after the third word is accepted, `xfer_start` pulses for one cycle. At that point `xfer_pos` holds word 1, `xfer_size` holds word 2, and `xfer_is_read` is 1 for 0xC0 and 0 for 0xA0.
- R9: After a 0xA0 start, input words go to `xfer_wdata` with `in_ready` = `xfer_wready`. These words are neither parsed nor forwarded until `xfer_done` is seen. After 0xC0, parsing resumes at once.
- R10: A packet whose words have not all arrived stays pending across idle input cycles and produces no output until it is completed.
- R11: After reset the status bits and all environment registers are 0, `pkt_valid` and `xfer_start` are 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input command word |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| pkt_valid | output | 1 | Drawing port word valid |
| pkt_data | output | 32 | Drawing port word |
| pkt_last | output | 1 | Final word of the packet |
| pkt_ready | input | 1 | Drawing port accepts the word |
| stat_bits | output | 13 | Texture-page (10:0) and mask (12:11) status |
| env_regs | output | 256 | Eight environment registers, register k at bits 32k+31:32k |
| xfer_start | output | 1 | One-cycle rectangle transfer start |
| xfer_is_read | output | 1 | Transfer direction: 1 read, 0 write |
| xfer_pos | output | 32 | Transfer position word |
| xfer_size | output | 32 | Transfer size word |
| xfer_wvalid | output | 1 | Write-transfer data valid |
| xfer_wdata | output | 32 | Write-transfer data |
| xfer_wready | input | 1 | Transfer engine accepts data |
| xfer_done | input | 1 | Transfer engine finished the write |

## Verification
A word counter that goes wrong first shows up as a packet of the wrong length on the drawing port. Because framing is lost, every later header is then read at the wrong position. The bench therefore checks each length and last flag, and then checks that a following environment command still lands in the right register. A snoop that reads the wrong buffered word is visible on the status bits in the cycle after the packet completes. A missed exit from write-transfer mode shows up as words silently swallowed into `xfer_wdata`, with no packet or register change after `xfer_done`.

// File: rtl/drawcmd_pkg.sv
package drawcmd_pkg;

    localparam int STAT_W = 13;

    typedef logic [7:0] cmd_t;

    typedef enum logic [1:0] {
        ST_COLLECT,
        ST_DRAIN,
        ST_RECT_WR
    } pstate_e;

    typedef struct packed {
        logic [3:0] params;
        logic       tex_flat;
        logic       tex_shaded;
        logic       env_wr;
        logic       tpage_set;
        logic       mask_set;
        logic       rect_wr;
        logic       rect_rd;
    } cmd_info_t;

    // Parameter words that follow a header with this code.
    function automatic logic [3:0] param_count(cmd_t c);
        logic [3:0] n;
        n = 4'd0;
        if (c[7:5] == 3'b001) begin
            case (c[4:2])
                3'd0:    n = 4'd3;
                3'd1:    n = 4'd6;
                3'd2:    n = 4'd4;
                3'd3:    n = 4'd8;
                3'd4:    n = 4'd5;
                3'd5:    n = 4'd8;
                3'd6:    n = 4'd7;
                default: n = 4'd11;
            endcase
        end else if (c == 8'h02) begin
            n = 4'd2;
        end else if (c[7:2] == 6'b011000) begin
            n = 4'd2;
        end else if (c[7:2] == 6'b011010) begin
            n = 4'd1;
        end else if (c == 8'h80) begin
            n = 4'd3;
        end else if (c == 8'hA0 || c == 8'hC0) begin
            n = 4'd2;
        end
        return n;
    endfunction

endpackage

// File: rtl/dcp_cmd_decode.sv
module dcp_cmd_decode
    import drawcmd_pkg::*;
(
    input  cmd_t      cmd,
    output cmd_info_t info
);

    always_comb begin
        info            = '0;
        info.params     = param_count(cmd);
        info.tex_flat   = ((cmd & 8'hF4) == 8'h24);
        info.tex_shaded = ((cmd & 8'hF4) == 8'h34);
        info.env_wr     = (cmd[7:3] == 5'b11100);
        info.tpage_set  = (cmd == 8'hE1);
        info.mask_set   = (cmd == 8'hE6);
        info.rect_wr    = (cmd == 8'hA0);
        info.rect_rd    = (cmd == 8'hC0);
    end

endmodule

// File: rtl/dcp_pkt_store.sv
module dcp_pkt_store #(
    parameter int  DEPTH = 12,
    parameter int  W     = 32,
    parameter int  NRD   = 2,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [W-1:0]      wr_data,
    input  logic [NRD*IW-1:0] rd_idx,
    output logic [NRD*W-1:0]  rd_data
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_data[g*W +: W] = mem[rd_idx[g*IW +: IW]];
    end

endmodule

// File: rtl/dcp_env_snoop.sv
module dcp_env_snoop
    import drawcmd_pkg::*;
#(
    parameter int  W     = 32,
    parameter int  ENV_N = 8,
    localparam int EIW   = $clog2(ENV_N)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               commit,
    input  cmd_info_t          info,
    input  cmd_t               cmd,
    input  logic [W-1:0]       cur_word,
    input  logic [W-1:0]       tex_word,
    output logic [STAT_W-1:0]  stat,
    output logic [ENV_N*W-1:0] env_flat
);

    logic [W-1:0]      env_q [ENV_N];
    logic [STAT_W-1:0] stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            for (int k = 0; k < ENV_N; k++) begin
                env_q[k] <= '0;
            end
        end else if (commit) begin
            if (info.tex_flat || info.tex_shaded) begin
                stat_q[8:0] <= tex_word[8:0];
            end
            if (info.tpage_set) begin
                stat_q[10:0] <= cur_word[10:0];
            end
            if (info.mask_set) begin
                stat_q[12:11] <= cur_word[1:0];
            end
            if (info.env_wr) begin
                env_q[cmd[EIW-1:0]] <= cur_word;
            end
        end
    end

    assign stat = stat_q;

    for (genvar g = 0; g < ENV_N; g++) begin : g_env
        assign env_flat[g*W +: W] = env_q[g];
    end

    AST_ENV_HOLD:  assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(env_flat));  // R7
    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(stat));      // R5

endmodule

// File: rtl/draw_cmd_parser.sv
module draw_cmd_parser
    import drawcmd_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int MAX_PKT = 12,
    parameter int ENV_N   = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [WORD_W-1:0]       in_data,
    output logic                    in_ready,
    output logic                    pkt_valid,
    output logic [WORD_W-1:0]       pkt_data,
    output logic                    pkt_last,
    input  logic                    pkt_ready,
    output logic [STAT_W-1:0]       stat_bits,
    output logic [ENV_N*WORD_W-1:0] env_regs,
    output logic                    xfer_start,
    output logic                    xfer_is_read,
    output logic [WORD_W-1:0]       xfer_pos,
    output logic [WORD_W-1:0]       xfer_size,
    output logic                    xfer_wvalid,
    output logic [WORD_W-1:0]       xfer_wdata,
    input  logic                    xfer_wready,
    input  logic                    xfer_done
);

    localparam int IDX_W = $clog2(MAX_PKT);
    localparam int LEN_W = IDX_W + 1;

    pstate_e           state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  rd_ptr_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  cur_len;
    cmd_t              cmd_q;
    cmd_t              cur_cmd;
    cmd_info_t         cur_info;
    logic              accept;
    logic              commit;
    logic              is_rect;
    logic [IDX_W-1:0]  tap_idx;
    logic [WORD_W-1:0] tap_word;
    logic [2*IDX_W-1:0]  rd_idx;
    logic [2*WORD_W-1:0] rd_data;

    logic              xs_q;
    logic              xr_q;
    logic [WORD_W-1:0] xpos_q;
    logic [WORD_W-1:0] xsize_q;

    // Header code comes live from the input on word 0, then from the latch.
    assign cur_cmd = (idx_q == '0) ? in_data[WORD_W-1 -: 8] : cmd_q;

    dcp_cmd_decode u_dec (
        .cmd  (cur_cmd),
        .info (cur_info)
    );

    assign cur_len = LEN_W'(cur_info.params) + LEN_W'(1);
    assign accept  = (state_q == ST_COLLECT) && in_valid;
    assign commit  = accept && ({1'b0, idx_q} == cur_len - LEN_W'(1));
    assign is_rect = cur_info.rect_wr || cur_info.rect_rd;

    always_comb begin
        if (is_rect) begin
            tap_idx = IDX_W'(1);
        end else if (cur_info.tex_shaded) begin
            tap_idx = IDX_W'(5);
        end else begin
            tap_idx = IDX_W'(4);
        end
    end

    assign rd_idx = {tap_idx, rd_ptr_q};

    dcp_pkt_store #(
        .DEPTH (MAX_PKT),
        .W     (WORD_W),
        .NRD   (2)
    ) u_store (
        .clk     (clk),
        .wr_en   (accept),
        .wr_idx  (idx_q),
        .wr_data (in_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    assign pkt_data = rd_data[WORD_W-1:0];
    assign tap_word = rd_data[2*WORD_W-1 -: WORD_W];

    dcp_env_snoop #(
        .W     (WORD_W),
        .ENV_N (ENV_N)
    ) u_snoop (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .info     (cur_info),
        .cmd      (cur_cmd),
        .cur_word (in_data),
        .tex_word (tap_word),
        .stat     (stat_bits),
        .env_flat (env_regs)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_COLLECT;
            idx_q    <= '0;
            rd_ptr_q <= '0;
            len_q    <= '0;
            cmd_q    <= '0;
            xs_q     <= 1'b0;
            xr_q     <= 1'b0;
            xpos_q   <= '0;
            xsize_q  <= '0;
        end else begin
            xs_q <= 1'b0;
            case (state_q)
                ST_COLLECT: begin
                    if (accept) begin
                        if (idx_q == '0) begin
                            cmd_q <= cur_cmd;
                        end
                        if (commit) begin
                            idx_q <= '0;
                            if (is_rect) begin
                                xs_q    <= 1'b1;
                                xr_q    <= cur_info.rect_rd;
                                xpos_q  <= tap_word;
                                xsize_q <= in_data;
                                state_q <= cur_info.rect_wr ? ST_RECT_WR : ST_COLLECT;
                            end else begin
                                len_q    <= cur_len;
                                rd_ptr_q <= '0;
                                state_q  <= ST_DRAIN;
                            end
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (pkt_ready) begin
                        if (pkt_last) begin
                            state_q <= ST_COLLECT;
                        end else begin
                            rd_ptr_q <= rd_ptr_q + 1'b1;
                        end
                    end
                end
                ST_RECT_WR: begin
                    if (xfer_done) begin
                        state_q <= ST_COLLECT;
                    end
                end
                default: state_q <= ST_COLLECT;
            endcase
        end
    end

    assign in_ready     = (state_q == ST_COLLECT) ||
                          ((state_q == ST_RECT_WR) && xfer_wready);
    assign pkt_valid    = (state_q == ST_DRAIN);
    assign pkt_last     = ({1'b0, rd_ptr_q} == len_q - LEN_W'(1));
    assign xfer_start   = xs_q;
    assign xfer_is_read = xr_q;
    assign xfer_pos     = xpos_q;
    assign xfer_size    = xsize_q;
    assign xfer_wvalid  = (state_q == ST_RECT_WR) && in_valid;
    assign xfer_wdata   = in_data;

    AST_IDX_BOUND:       assert property (@(posedge clk) disable iff (rst)
        accept |-> (int'(idx_q) < MAX_PKT));                         // R1
    AST_DRAIN_STALLS_IN: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> !in_ready);                                    // R2
    AST_LAST_ENDS_PKT:   assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_ready && pkt_last) |=> !pkt_valid);        // R2
    AST_STALL_STABLE:    assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !pkt_ready) |=>
            (pkt_valid && $stable(pkt_data) && $stable(pkt_last)));  // R3
    AST_START_PULSE:     assert property (@(posedge clk) disable iff (rst)
        xfer_start |=> !xfer_start);                                 // R8
    AST_WR_NO_PKT:       assert property (@(posedge clk) disable iff (rst)
        xfer_wvalid |-> !pkt_valid);                                 // R9

endmodule

// File: tb/sim_draw_cmd_parser.sv
`timescale 1ns/1ps
module sim_draw_cmd_parser;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [31:0]  in_data = '0;
    logic         in_ready;
    logic         pkt_valid;
    logic [31:0]  pkt_data;
    logic         pkt_last;
    logic         pkt_ready = 1'b1;
    logic [12:0]  stat_bits;
    logic [255:0] env_regs;
    logic         xfer_start;
    logic         xfer_is_read;
    logic [31:0]  xfer_pos;
    logic [31:0]  xfer_size;
    logic         xfer_wvalid;
    logic [31:0]  xfer_wdata;
    logic         xfer_wready = 1'b1;
    logic         xfer_done = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [31:0] cap_w [256];
    logic        cap_l [256];
    int          n_cap = 0;
    logic [31:0] xw [64];
    int          n_xw = 0;

    always #2.5 clk = ~clk;

    draw_cmd_parser u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .pkt_last(pkt_last), .pkt_ready(pkt_ready), .stat_bits(stat_bits),
        .env_regs(env_regs), .xfer_start(xfer_start), .xfer_is_read(xfer_is_read),
        .xfer_pos(xfer_pos), .xfer_size(xfer_size), .xfer_wvalid(xfer_wvalid),
        .xfer_wdata(xfer_wdata), .xfer_wready(xfer_wready), .xfer_done(xfer_done)
    );

    always @(negedge clk) begin
        if (pkt_valid && pkt_ready && n_cap < 256) begin
            cap_w[n_cap] = pkt_data;
            cap_l[n_cap] = pkt_last;
            n_cap++;
        end
        if (xfer_wvalid && xfer_wready && n_xw < 64) begin
            xw[n_xw] = xfer_wdata;
            n_xw++;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Called at posedge+1; returns at posedge+1 after the word was accepted.
    task automatic push(input logic [31:0] w);
        bit ok;
        in_valid = 1'b1;
        in_data  = w;
        do begin
            @(negedge clk);
            ok = in_ready;
            @(posedge clk);
            #1;
        end while (!ok);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    function automatic logic [31:0] pword(input logic [7:0] cmd, input int i, input logic [31:0] salt);
        return (i == 0) ? {cmd, salt[23:0]} : (salt ^ (32'h0101_0000 * i) ^ i);
    endfunction

    task automatic send_and_check(input string req, input logic [7:0] cmd,
                                  input int len, input logic [31:0] salt);
        int base;
        int bad;
        base = n_cap;
        for (int i = 0; i < len; i++) push(pword(cmd, i, salt));
        idle(len + 4);
        chk(req, $sformatf("length of code %02h", cmd), 64'(n_cap - base), 64'(len));
        bad = 0;
        for (int i = 0; i < len; i++) begin
            if (cap_w[base+i] !== pword(cmd, i, salt)) bad++;
            if (cap_l[base+i] !== (i == len - 1)) bad++;
        end
        chk(req, $sformatf("words/last of code %02h", cmd), 64'(bad), 64'd0);
    endtask

    task automatic t_reset;
        chk("R11", "status", 64'(stat_bits), 64'd0);
        chk("R11", "env", 64'(env_regs != '0), 64'd0);
        chk("R11", "pkt_valid", 64'(pkt_valid), 64'd0);
        chk("R11", "xfer_start", 64'(xfer_start), 64'd0);
        chk("R11", "in_ready", 64'(in_ready), 64'd1);
    endtask

    task automatic t_lengths;  // R1
        send_and_check("R1", 8'h20, 4, 32'h1111_0000);
        send_and_check("R1", 8'h2D, 9, 32'h2222_0000);
        send_and_check("R1", 8'h3F, 12, 32'h3333_0000);
        send_and_check("R1", 8'h02, 3, 32'h4444_0000);
        send_and_check("R1", 8'h61, 3, 32'h5555_0000);
        send_and_check("R1", 8'h6A, 2, 32'h6666_0000);
        send_and_check("R1", 8'h80, 4, 32'h7777_0000);
        send_and_check("R1", 8'h39, 8, 32'h8888_0000);
        send_and_check("R1", 8'h2A, 5, 32'h9999_0000);
    endtask

    task automatic t_unlisted;  // R4
        send_and_check("R4", 8'h00, 1, 32'hAAAA_0000);
        send_and_check("R4", 8'h45, 1, 32'hBBBB_0000);
        send_and_check("R4", 8'hFF, 1, 32'hCCCC_0000);
    endtask

    task automatic t_texture;  // R5
        logic [31:0] w;
        for (int i = 0; i < 7; i++) begin
            w = (i == 4) ? 32'hFFFF_F0A5 : ((i == 0) ? 32'h2400_0000 : 32'h0000_0100 * i);
            push(w);
        end
        chk("R5", "flat textured word 4", 64'(stat_bits[8:0]), 64'h0A5);
        idle(12);
        for (int i = 0; i < 9; i++) begin
            w = (i == 5) ? 32'h1234_535A : ((i == 4) ? 32'h0000_01FF :
                ((i == 0) ? 32'h3600_0000 : 32'd0));
            push(w);
        end
        chk("R5", "shaded textured word 5", 64'(stat_bits[8:0]), 64'h15A);
        idle(12);
    endtask

    task automatic t_env;  // R6 R7
        int base;
        base = n_cap;
        push(32'hE100_0555);
        chk("R6", "tpage bits", 64'(stat_bits[10:0]), 64'h555);
        idle(3);
        push(32'hE600_0002);
        chk("R6", "mask bits keep tpage", 64'(stat_bits), 64'({2'b10, 11'h555}));
        idle(3);
        push(32'hE3AB_CDEF);
        idle(3);
        chk("R7", "env reg 1", 64'(env_regs[32*1 +: 32]), 64'hE100_0555);
        chk("R7", "env reg 6", 64'(env_regs[32*6 +: 32]), 64'hE600_0002);
        chk("R7", "env reg 3", 64'(env_regs[32*3 +: 32]), 64'hE3AB_CDEF);
        chk("R7", "env cmds forwarded", 64'(n_cap - base), 64'd3);
    endtask

    task automatic t_backpressure;  // R2 R3
        int base;
        base = n_cap;
        pkt_ready = 1'b0;
        push(32'h6000_0001);
        push(32'h0000_0002);
        chk("R2", "no output before last word", 64'(pkt_valid), 64'd0);
        push(32'h0000_0003);
        chk("R3", "valid under stall", 64'(pkt_valid), 64'd1);
        chk("R3", "data under stall", 64'(pkt_data), 64'h6000_0001);
        idle(4);
        chk("R3", "data held", 64'(pkt_data), 64'h6000_0001);
        chk("R2", "input stalled during drain", 64'(in_ready), 64'd0);
        pkt_ready = 1'b1;
        idle(6);
        chk("R3", "words after release", 64'(n_cap - base), 64'd3);
        chk("R3", "last word", 64'(cap_w[base+2]), 64'h0000_0003);
    endtask

    task automatic t_pending;  // R10
        int base;
        base = n_cap;
        push(32'h2B00_0010);
        push(32'h0000_0011);
        idle(6);
        chk("R10", "partial packet held", 64'(n_cap - base), 64'd0);
        chk("R10", "no valid while pending", 64'(pkt_valid), 64'd0);
        push(32'h0000_0012);
        push(32'h0000_0013);
        push(32'h0000_0014);
        idle(8);
        chk("R10", "completed packet", 64'(n_cap - base), 64'd5);
        chk("R10", "first word", 64'(cap_w[base]), 64'h2B00_0010);
    endtask

    task automatic t_rect_read;  // R8 R9
        int base;
        base = n_cap;
        push(32'hC000_0000);
        push(32'h0020_0040);
        push(32'h0010_0008);
        chk("R8", "read start", 64'(xfer_start), 64'd1);
        chk("R8", "read dir", 64'(xfer_is_read), 64'd1);
        chk("R8", "read pos", 64'(xfer_pos), 64'h0020_0040);
        chk("R8", "read size", 64'(xfer_size), 64'h0010_0008);
        idle(1);
        chk("R8", "start one cycle", 64'(xfer_start), 64'd0);
        push(32'hE200_0042);
        chk("R9", "parsing after read", 64'(env_regs[32*2 +: 32]), 64'hE200_0042);
        idle(3);
        chk("R8", "read cmd not forwarded", 64'(n_cap - base), 64'd1);
    endtask

    task automatic t_rect_write;  // R8 R9
        int base;
        int xbase;
        base  = n_cap;
        xbase = n_xw;
        push(32'hA000_0000);
        push(32'h0003_0005);
        push(32'h0002_0002);
        chk("R8", "write start", 64'(xfer_start), 64'd1);
        chk("R8", "write dir", 64'(xfer_is_read), 64'd0);
        chk("R8", "write size", 64'(xfer_size), 64'h0002_0002);
        push(32'hDEAD_BEEF);
        push(32'hE500_0001);
        push(32'h0000_7FFF);
        idle(2);
        chk("R9", "words to engine", 64'(n_xw - xbase), 64'd3);
        chk("R9", "engine word", 64'(xw[xbase+1]), 64'hE500_0001);
        chk("R9", "env untouched in write", 64'(env_regs[32*5 +: 32]), 64'd0);
        chk("R9", "nothing forwarded", 64'(n_cap - base), 64'd0);
        xfer_wready = 1'b0;
        in_valid    = 1'b1;
        in_data     = 32'h1;
        @(negedge clk);
        chk("R9", "in_ready follows engine", 64'(in_ready), 64'd0);
        @(posedge clk);
        #1;
        in_valid    = 1'b0;
        xfer_wready = 1'b1;
        xfer_done   = 1'b1;
        @(posedge clk);
        #1;
        xfer_done = 1'b0;
        push(32'hE500_0077);
        chk("R9", "parsing after done", 64'(env_regs[32*5 +: 32]), 64'hE500_0077);
        idle(3);
        chk("R9", "packet after done", 64'(n_cap - base), 64'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_lengths();
        t_unlisted();
        t_texture();
        t_env();
        t_backpressure();
        t_pending();
        t_rect_read();
        t_rect_write();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule